// File: doc/BRIEF.md
# Polled Mailbox Command Sequencer

This block runs one complete mailbox exchange on behalf of a single requester. The requester supplies a command byte, a subcommand byte, a parameter field and a 32-bit request payload, then pulses a start strobe. The block takes over from there. It waits until the mailbox reports idle and stores the payload. It then sends a packed command word that sets the busy flag. It waits for the device to clear that flag again and fetches the response payload.

Every access to the device goes through a request/acknowledge register port with one access outstanding at a time. The block ends each exchange with a one-cycle done pulse and a two-bit result code. The code separates a good completion, a mailbox that stayed busy for too long, a failure status from the device, and an error reported by the register port itself.

Top module: `mbox_seq`

## Requirements
- R1: After reset, busy_o, done_o and reg_req_o are all low.
- R2: After an accepted start, the block reads offset 0xA4 until a read returns bit 31 clear. It then writes the request payload to offset 0xA0, and only after that writes the command word to offset 0xA4.
- R3: The command word holds param_i[13:0] in bits 29:16, sub_i in bits 15:8 and cmd_i in bits 7:0, with bit 31 set and bit 30 clear.
- R4: Each of the two polling phases makes at most 100 reads. If the 100th read still shows bit 31 set, the exchange ends with result 1 (busy-timeout) and no further access is made. If bit 31 is clear on the 100th read, the exchange goes on.
- R5: After the command write, the block polls offset 0xA4 again under the same limit. The whole exchange makes exactly the sequence of accesses described by R2, R4, R6 and R7.
- R6: In the second phase, a read with bit 31 clear and a nonzero bits 7:0 ends the exchange with result 2 (device error), and offset 0xA0 is never read.
- R7: In the second phase, a read with bit 31 clear and zero bits 7:0 is followed by one read of offset 0xA0. That value appears on resp_data_o with result 0 (ok). Any result other than ok leaves resp_data_o unchanged.
- R8: An acknowledge that comes with reg_err_i set ends the exchange at once with result 3 (bus error), and no further access is made.
- R9: done_o is high for exactly one cycle per exchange, with result_o valid in that cycle. busy_o is high from the cycle after the accepted start until done_o.
- R10: A start while busy_o is high is ignored. The exchange in progress keeps its latched command fields and produces one done pulse. Inputs that change after start do not alter the exchange.
- R11: While reg_req_o is high and reg_ack_i low, reg_req_o, reg_addr_o, reg_we_o and reg_wdata_o hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| cmd_i | input | 8 | Command byte |
| sub_i | input | 8 | Subcommand byte |
| param_i | input | 16 | Parameter field; the low 14 bits are used |
| req_data_i | input | 32 | Request payload |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 busy-timeout, 2 device error, 3 bus error |
| resp_data_o | output | 32 | Response payload of the last good exchange |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 write, 0 read |
| reg_addr_o | output | 8 | Register offset |
| reg_wdata_o | output | 32 | Write data |
| reg_ack_i | input | 1 | Access acknowledge |
| reg_err_i | input | 1 | Access error, valid with acknowledge |
| reg_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The bench uses the default parameters: a 100-read polling limit, offsets 0xA0 and 0xA4, a 14-bit parameter field placed at bit 16, and an 8-bit status byte. With a register model that answers after 0 to 3 wait cycles, both polling boundaries can be tested directly. The 99-busy case completes and the 100-busy case times out, in each phase, within a few hundred cycles. The same setup covers a bus error injected at any position in the access sequence.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_DEVERR  = 2'd2,
        RES_BUSERR  = 2'd3
    } mbox_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_PRE,
        ST_WR_DATA,
        ST_WR_CMD,
        ST_POLL_POST,
        ST_RD_DATA
    } mbox_st_e;
endpackage

// File: rtl/mbox_cmd_pack.sv
`timescale 1ns/1ps
module mbox_cmd_pack #(
    parameter int DATA_W     = 32,
    parameter int CMD_W      = 8,
    parameter int SUB_W      = 8,
    parameter int PARAM_IN_W = 16,
    parameter int PARAM_W    = 14,
    parameter int PARAM_LSB  = 16,
    parameter int BUSY_BIT   = 31
) (
    input  logic [CMD_W-1:0]      cmd_i,
    input  logic [SUB_W-1:0]      sub_i,
    input  logic [PARAM_IN_W-1:0] param_i,
    output logic [DATA_W-1:0]     word_o
);
    always_comb begin
        word_o                      = '0;
        word_o[CMD_W-1:0]           = cmd_i;
        word_o[CMD_W +: SUB_W]      = sub_i;
        word_o[PARAM_LSB +: PARAM_W] = param_i[PARAM_W-1:0];
        word_o[BUSY_BIT]            = 1'b1;
    end
endmodule

// File: rtl/mbox_poll_ctr.sv
`timescale 1ns/1ps
module mbox_poll_ctr #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mbox_seq.sv
`timescale 1ns/1ps
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 32,
    parameter int              CMD_W      = 8,
    parameter int              SUB_W      = 8,
    parameter int              PARAM_IN_W = 16,
    parameter int              PARAM_W    = 14,
    parameter int              PARAM_LSB  = 16,
    parameter int              BUSY_BIT   = 31,
    parameter int              STAT_W     = 8,
    parameter int              MAX_POLLS  = 100,
    parameter logic [ADDR_W-1:0] DATA_OFS = 8'hA0,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 8'hA4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [CMD_W-1:0]      cmd_i,
    input  logic [SUB_W-1:0]      sub_i,
    input  logic [PARAM_IN_W-1:0] param_i,
    input  logic [DATA_W-1:0]     req_data_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [1:0]            result_o,
    output logic [DATA_W-1:0]     resp_data_o,
    output logic                  reg_req_o,
    output logic                  reg_we_o,
    output logic [ADDR_W-1:0]     reg_addr_o,
    output logic [DATA_W-1:0]     reg_wdata_o,
    input  logic                  reg_ack_i,
    input  logic                  reg_err_i,
    input  logic [DATA_W-1:0]     reg_rdata_i
);
    typedef struct packed {
        mbox_st_e          st;
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] payload;
        logic [DATA_W-1:0] cmd_word;
        logic              done;
        mbox_res_e         res;
        logic [DATA_W-1:0] resp;
    } seq_t;

    seq_t s_d, s_q;

    logic [DATA_W-1:0] packed_word;
    logic              cnt_clr, cnt_inc, cnt_last;
    logic              rd_busy, rd_fail;

    mbox_cmd_pack #(
        .DATA_W(DATA_W), .CMD_W(CMD_W), .SUB_W(SUB_W),
        .PARAM_IN_W(PARAM_IN_W), .PARAM_W(PARAM_W),
        .PARAM_LSB(PARAM_LSB), .BUSY_BIT(BUSY_BIT)
    ) u_pack (
        .cmd_i  (cmd_i),
        .sub_i  (sub_i),
        .param_i(param_i),
        .word_o (packed_word)
    );

    mbox_poll_ctr #(.LIMIT(MAX_POLLS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .last_o(cnt_last)
    );

    assign rd_busy = reg_rdata_i[BUSY_BIT];
    assign rd_fail = |reg_rdata_i[STAT_W-1:0];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;

        if (s_q.st == ST_IDLE) begin
            if (start_i) begin
                s_d.payload  = req_data_i;
                s_d.cmd_word = packed_word;
                s_d.st       = ST_POLL_PRE;
                cnt_clr      = 1'b1;
            end
        end else if (!s_q.req) begin
            // launch the access that belongs to the current step
            s_d.req   = 1'b1;
            s_d.we    = (s_q.st == ST_WR_DATA) || (s_q.st == ST_WR_CMD);
            s_d.addr  = ((s_q.st == ST_WR_DATA) || (s_q.st == ST_RD_DATA)) ? DATA_OFS : CMD_OFS;
            s_d.wdata = (s_q.st == ST_WR_DATA) ? s_q.payload : s_q.cmd_word;
        end else if (reg_ack_i) begin
            s_d.req = 1'b0;
            if (reg_err_i) begin
                s_d.done = 1'b1;
                s_d.res  = RES_BUSERR;
                s_d.st   = ST_IDLE;
            end else begin
                unique case (s_q.st)
                    ST_POLL_PRE: begin
                        if (!rd_busy) begin
                            s_d.st = ST_WR_DATA;
                        end else if (cnt_last) begin
                            s_d.done = 1'b1;
                            s_d.res  = RES_TIMEOUT;
                            s_d.st   = ST_IDLE;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                    ST_WR_DATA: s_d.st = ST_WR_CMD;
                    ST_WR_CMD: begin
                        s_d.st  = ST_POLL_POST;
                        cnt_clr = 1'b1;
                    end
                    ST_POLL_POST: begin
                        if (!rd_busy) begin
                            if (rd_fail) begin
                                s_d.done = 1'b1;
                                s_d.res  = RES_DEVERR;
                                s_d.st   = ST_IDLE;
                            end else begin
                                s_d.st = ST_RD_DATA;
                            end
                        end else if (cnt_last) begin
                            s_d.done = 1'b1;
                            s_d.res  = RES_TIMEOUT;
                            s_d.st   = ST_IDLE;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                    ST_RD_DATA: begin
                        s_d.resp = reg_rdata_i;
                        s_d.done = 1'b1;
                        s_d.res  = RES_OK;
                        s_d.st   = ST_IDLE;
                    end
                    default: s_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, res: RES_OK, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = s_q.done;
    assign result_o    = s_q.res;
    assign resp_data_o = s_q.resp;
    assign reg_req_o   = s_q.req;
    assign reg_we_o    = s_q.we;
    assign reg_addr_o  = s_q.addr;
    assign reg_wdata_o = s_q.wdata;
endmodule

// File: rtl/mbox_seq_chk.sv
`timescale 1ns/1ps
module mbox_seq_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                BUSY_BIT = 31,
    parameter logic [ADDR_W-1:0] DATA_OFS = 8'hA0,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 8'hA4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              reg_req_o,
    input logic              reg_we_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic [DATA_W-1:0] reg_wdata_o,
    input logic              reg_ack_i
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !reg_req_o);

    p_write_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && reg_we_o) |-> (reg_addr_o == DATA_OFS || reg_addr_o == CMD_OFS));

    p_cmd_busy_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && reg_we_o && reg_addr_o == CMD_OFS) |-> reg_wdata_o[BUSY_BIT]);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !reg_req_o));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o)
                                       && $stable(reg_we_o) && $stable(reg_wdata_o)));
endmodule

bind mbox_seq mbox_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT),
    .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .reg_req_o  (reg_req_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_ack_i  (reg_ack_i)
);

// File: tb/sim_mbox_seq.sv
`timescale 1ns/1ps
module sim_mbox_seq;
    localparam int POLLS = 100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [7:0]  cmd_i, sub_i;
    logic [15:0] param_i;
    logic [31:0] req_data_i;
    logic        busy_o, done_o;
    logic [1:0]  result_o;
    logic [31:0] resp_data_o;
    logic        reg_req_o, reg_we_o;
    logic [7:0]  reg_addr_o;
    logic [31:0] reg_wdata_o;
    logic        m_ack, m_err;
    logic [31:0] m_rdata;

    always #2.5 clk = ~clk;

    mbox_seq #(.MAX_POLLS(POLLS)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .sub_i(sub_i),
        .param_i(param_i), .req_data_i(req_data_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .resp_data_o(resp_data_o), .reg_req_o(reg_req_o),
        .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
        .reg_ack_i(m_ack), .reg_err_i(m_err), .reg_rdata_i(m_rdata)
    );

    // scenario for the register model
    int          sc_p1, sc_p2, sc_err_at;
    logic [7:0]  sc_status;
    logic [31:0] sc_resp;
    logic        clr_req;

    // model logs
    int          n_acc, n_p1, n_p2, n_drd, n_done, n_viol;
    logic        ph2;
    logic [31:0] wr_data_val, wr_cmd_val;
    int          lat;
    logic        prev_hold;
    logic [7:0]  prev_addr;
    logic        prev_we;

    always @(posedge clk) begin
        if (!rst_n || clr_req) begin
            m_ack <= 1'b0; m_err <= 1'b0; m_rdata <= '0; lat <= 0;
            n_acc <= 0; n_p1 <= 0; n_p2 <= 0; n_drd <= 0; ph2 <= 1'b0;
            wr_data_val <= '0; wr_cmd_val <= '0;
        end else if (m_ack) begin
            m_ack <= 1'b0;
            m_err <= 1'b0;
        end else if (reg_req_o) begin
            if (lat != 0) begin
                lat <= lat - 1;
            end else begin
                m_ack <= 1'b1;
                lat   <= int'($urandom_range(0, 3));
                m_err <= (n_acc == sc_err_at);
                n_acc <= n_acc + 1;
                if (reg_we_o) begin
                    if (reg_addr_o == 8'hA0) wr_data_val <= reg_wdata_o;
                    else begin wr_cmd_val <= reg_wdata_o; ph2 <= 1'b1; end
                end else if (reg_addr_o == 8'hA4) begin
                    if (!ph2) begin
                        m_rdata <= (n_p1 < sc_p1) ? {1'b1, 31'($urandom)} : {1'b0, 31'($urandom)};
                        n_p1 <= n_p1 + 1;
                    end else begin
                        m_rdata <= (n_p2 < sc_p2) ? {1'b1, 31'($urandom)}
                                                  : {1'b0, 23'($urandom), sc_status};
                        n_p2 <= n_p2 + 1;
                    end
                end else begin
                    m_rdata <= sc_resp;
                    n_drd   <= n_drd + 1;
                end
            end
        end
    end

    // handshake monitor and done counter
    always @(posedge clk) begin
        if (!rst_n) begin
            n_done <= 0; n_viol <= 0; prev_hold <= 1'b0; prev_addr <= '0; prev_we <= 1'b0;
        end else begin
            if (done_o) n_done <= n_done + 1;
            if (prev_hold && (!reg_req_o || reg_addr_o != prev_addr || reg_we_o != prev_we))
                n_viol <= n_viol + 1;
            prev_hold <= reg_req_o && !m_ack;
            prev_addr <= reg_addr_o;
            prev_we   <= reg_we_o;
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_word(input logic [7:0] c, input logic [7:0] s, input logic [15:0] p);
        return {1'b1, 1'b0, p[13:0], s, c};
    endfunction

    function automatic void exp_calc(input int p1, input int p2, input logic [7:0] st, input int err_at,
                                     output int res, output int nacc);
        int n;
        res = 0;
        if (p1 >= POLLS) begin
            res = 1; n = POLLS;
        end else begin
            n = p1 + 1 + 2;
            if (p2 >= POLLS) begin
                res = 1; n += POLLS;
            end else begin
                n += p2 + 1;
                if (st != 0) res = 2;
                else n += 1;
            end
        end
        if (err_at >= 0 && err_at < n) begin
            res = 3; n = err_at + 1;
        end
        nacc = n;
    endfunction

    logic [31:0] exp_resp = '0;

    task automatic run(input logic [7:0] c, input logic [7:0] s, input logic [15:0] p, input logic [31:0] d,
                       input int p1, input int p2, input logic [7:0] st, input logic [31:0] rsp,
                       input int err_at, input bit mid_start);
        int e_res, e_acc, done_before, waited;
        bit got;
        @(negedge clk);
        sc_p1 = p1; sc_p2 = p2; sc_status = st; sc_resp = rsp; sc_err_at = err_at;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        done_before = n_done;
        cmd_i = c; sub_i = s; param_i = p; req_data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cmd_i = 8'($urandom); sub_i = 8'($urandom); param_i = 16'($urandom); req_data_i = $urandom;
        chk(busy_o == 1'b1, "R9 busy after start", 32'(busy_o), 32'd1);
        got = 0; waited = 0;
        while (!got && waited < 2000) begin
            if (mid_start && waited == 2) begin
                cmd_i = ~c; sub_i = ~s; param_i = ~p; req_data_i = ~d; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            waited++;
            if (done_o) got = 1;
        end
        chk(got, "R9 done seen", 32'(got), 32'd1);
        exp_calc(p1, p2, st, err_at, e_res, e_acc);
        if (e_res == 0) exp_resp = rsp;
        case (e_res)
            0: chk(result_o == 2'd0, "R7 result ok", 32'(result_o), 32'(e_res));
            1: chk(result_o == 2'd1, "R4 result timeout", 32'(result_o), 32'(e_res));
            2: chk(result_o == 2'd2, "R6 result device error", 32'(result_o), 32'(e_res));
            default: chk(result_o == 2'd3, "R8 result bus error", 32'(result_o), 32'(e_res));
        endcase
        chk(resp_data_o == exp_resp, "R7 response payload", resp_data_o, exp_resp);
        chk(n_acc == e_acc, "R5 access count", 32'(n_acc), 32'(e_acc));
        if (err_at < 0 && p1 < POLLS) begin
            chk(wr_data_val == d, "R2 payload write", wr_data_val, d);
            chk(wr_cmd_val == pack_word(c, s, p), "R3 command word", wr_cmd_val, pack_word(c, s, p));
            chk(n_p1 == p1 + 1, "R2 first phase reads", 32'(n_p1), 32'(p1 + 1));
        end
        if (e_res == 2)
            chk(n_drd == 0, "R6 no data read", 32'(n_drd), 32'd0);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", 32'(done_o), 32'd0);
        if (mid_start) begin
            repeat (10) @(negedge clk);
            chk(n_done == done_before + 1, "R10 single done", 32'(n_done), 32'(done_before + 1));
            chk(busy_o == 1'b0, "R10 no second exchange", 32'(busy_o), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R9 watchdog act=hung exp=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; start_i = 1'b0; clr_req = 1'b0;
        cmd_i = '0; sub_i = '0; param_i = '0; req_data_i = '0;
        sc_p1 = 0; sc_p2 = 0; sc_status = '0; sc_resp = '0; sc_err_at = -1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !reg_req_o, "R1 reset state",
            {29'd0, busy_o, done_o, reg_req_o}, 32'd0);

        // directed corners
        run(8'h7F, 8'h03, 16'hFFFF, 32'hDEAD_BEEF, 0, 0, 8'h00, 32'h1234_5678, -1, 0); // R7 quick path
        run(8'h11, 8'h22, 16'h2AAA, 32'h0BAD_F00D, 99, 3, 8'h00, 32'hCAFE_0001, -1, 0); // R4 edge pass
        run(8'h11, 8'h22, 16'h0001, 32'h1, 100, 0, 8'h00, 32'h5, -1, 0);               // R4 timeout phase 1
        run(8'h33, 8'h44, 16'h1555, 32'h2, 2, 99, 8'h00, 32'hAAAA_5555, -1, 0);        // R5 edge pass
        run(8'h33, 8'h44, 16'h1555, 32'h3, 2, 100, 8'h00, 32'h6, -1, 0);               // R5 timeout phase 2
        run(8'h55, 8'h66, 16'h0F0F, 32'h4, 1, 2, 8'h5A, 32'h7, -1, 0);                 // R6 device error
        run(8'h55, 8'h66, 16'h0F0F, 32'h5, 1, 2, 8'h00, 32'h8, 0, 0);                  // R8 first access
        run(8'h55, 8'h66, 16'h0F0F, 32'h6, 3, 0, 8'h00, 32'h9, 4, 0);                  // R8 payload write
        run(8'h55, 8'h66, 16'h0F0F, 32'h7, 0, 0, 8'h00, 32'hA, 4, 0);                  // R8 final data read
        run(8'h99, 8'hAB, 16'h3C3C, 32'h8, 5, 1, 8'h00, 32'h0F0F_F0F0, -1, 1);         // R10 start while busy

        // random mix
        for (int i = 0; i < 40; i++) begin
            int p1r, p2r, er;
            logic [7:0] str;
            p1r = int'($urandom_range(0, 6));
            p2r = int'($urandom_range(0, 6));
            str = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(1, 255)) : 8'h00;
            er  = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 12)) : -1;
            run(8'($urandom), 8'($urandom), 16'($urandom), $urandom, p1r, p2r, str, $urandom, er,
                bit'($urandom_range(0, 5) == 0));
        end

        chk(n_viol == 0, "R11 request held until acknowledge", 32'(n_viol), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule